// File: doc/BRIEF.md
# 1-Wire Slave Slot Front-End

This block connects a 1-Wire slave to the open-drain data line. It times every low pulse that a bus master puts on the line, in microseconds, from a tick derived from the system clock. When the line returns high it sorts the pulse into one of three kinds: a bus reset, a written 1 or a written 0. After a reset it answers with a presence pulse. During read slots it returns 0 bits on request from the ROM engine above it.

The ROM engine sees four one-cycle strobes. `slot_start` marks every falling edge made by the master. `bus_reset` and `bit_valid`/`bit_value` report the class of each pulse when it ends. The engine returns a 0 bit by holding `tx_zero_req` high in the cycle where `slot_start` is high. For a 1 bit it leaves the request low, and the pull-up holds the line high. Read slots go through the same low-time thresholds as write slots, so a short read slot that the block leaves released is also reported as a bit of value 1.

Top module: `owire_slot_front`

## Requirements
- R1: After a synchronous reset all strobes are low and `line_pull` is low, which leaves the line released.
- R2: A low pulse longer than 256 µs, measured when the line rises, gives one `bus_reset` strobe and no `bit_valid`. A low of exactly 256 µs is a bit and not a reset.
- R3: From the cycle after `bus_reset`, `line_pull` is high for exactly 120 µs (120 × CLK_PER_US cycles) as the presence pulse, and then drops.
- R4: A low pulse of 15 µs or less gives `bit_valid` with `bit_value` = 1.
- R5: A low pulse of 16 µs up to 256 µs gives `bit_valid` with `bit_value` = 0.
- R6: Every falling edge made by the master gives one `slot_start` pulse, one cycle long.
- R7: If `tx_zero_req` is high in the `slot_start` cycle, `line_pull` rises in the next cycle and stays high for exactly 15 µs. A request raised only after that cycle does not drive the line.
- R8: Edges that arrive while the block drives the line, or within the guard cycles just after it releases, give no strobe. In particular, a read slot that returns 0 reports no bit.
- R9: The low-time counter saturates instead of wrapping, so a 600 µs low is still a reset.
- R10: A reset wins over a pending transmit-zero request. With `tx_zero_req` high when `bus_reset` fires, the drive lasts the full presence length.
- R11: The line input passes through two synchronizer flops. `slot_start`, `bit_valid` and `bus_reset` go high on the third rising clock edge after the line changes, and a drive starts one edge after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw level of the 1-Wire data line |
| tx_zero_req | input | 1 | ROM engine asks for a 0 bit in the current read slot (sampled with `slot_start`) |
| line_pull | output | 1 | High while the block pulls the line low |
| bus_reset | output | 1 | One-cycle strobe: a reset pulse has ended |
| slot_start | output | 1 | One-cycle strobe: the master made a falling edge |
| bit_valid | output | 1 | One-cycle strobe: a write or read slot has been decoded |
| bit_value | output | 1 | Decoded bit, meaningful while `bit_valid` is high |

## Verification
A reset decision and a transmit-zero request can fall in the same cycle. The ROM engine may still hold `tx_zero_req` high when the rising edge that ends a long low produces `bus_reset`. The bench provokes this by raising the request partway through reset-length lows and holding it past the release, both in directed cases and in random ones. It judges the outcome by counting the cycles of `line_pull`, which must equal the presence length and never the short zero-bit length. The same late request during ordinary write slots must leave the line untouched and the decoded bit unchanged.

// File: rtl/owsf_pkg.sv
`timescale 1ns/1ps
package owsf_pkg;

    typedef enum logic [1:0] {
        DRV_IDLE = 2'd0,
        DRV_TXZ  = 2'd1,
        DRV_PRES = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } line_evt_t;

    typedef struct packed {
        logic rst_det;
        logic bit_ok;
        logic bit_val;
    } slot_res_t;

    function automatic slot_res_t classify(input int unsigned low_us,
                                           input int unsigned reset_us,
                                           input int unsigned one_max_us);
        slot_res_t r;
        r.rst_det = (low_us > reset_us);
        r.bit_ok  = !r.rst_det;
        r.bit_val = r.bit_ok && (low_us <= one_max_us);
        return r;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/owsf_sync.sv
`timescale 1ns/1ps
module owsf_sync
    import owsf_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_raw,
    input  logic      blank,
    output line_evt_t evt
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              level;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_raw};
            prev  <= level;
        end
    end

    assign level = chain[STAGES-1];

    always_comb begin
        evt.level = level;
        evt.fall  = prev & ~level & ~blank;
        evt.rise  = ~prev & level & ~blank;
    end

endmodule

// File: rtl/owsf_lowtime.sv
`timescale 1ns/1ps
module owsf_lowtime
    import owsf_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 200,
    parameter int unsigned CNT_W      = 9,
    parameter int unsigned RESET_US   = 256,
    parameter int unsigned ONE_MAX_US = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    input  logic      blank,
    output logic      bus_reset,
    output logic      slot_start,
    output logic      bit_valid,
    output logic      bit_value
);
    localparam int unsigned PS_W    = $clog2(CLK_PER_US);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [PS_W-1:0]  PS_TOP  = PS_W'(CLK_PER_US - 1);

    logic [PS_W-1:0]  ps;
    logic [CNT_W-1:0] low_us;
    slot_res_t        res;

    assign res = classify(32'(low_us), RESET_US, ONE_MAX_US);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps         <= '0;
            low_us     <= '0;
            bus_reset  <= 1'b0;
            slot_start <= 1'b0;
            bit_valid  <= 1'b0;
            bit_value  <= 1'b0;
        end else begin
            bus_reset  <= 1'b0;
            slot_start <= 1'b0;
            bit_valid  <= 1'b0;
            bit_value  <= 1'b0;
            if (evt.fall) begin
                // the edge cycle itself is the first low cycle seen
                ps         <= PS_W'(1);
                low_us     <= '0;
                slot_start <= 1'b1;
            end else if (!blank && !evt.level) begin
                if (ps == PS_TOP) begin
                    ps <= '0;
                    if (low_us != CNT_MAX) low_us <= low_us + 1'b1;
                end else begin
                    ps <= ps + 1'b1;
                end
            end
            if (evt.rise) begin
                bus_reset <= res.rst_det;
                bit_valid <= res.bit_ok;
                bit_value <= res.bit_val;
            end
        end
    end

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_reset && bit_valid));

    assert_slot_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !slot_start);

    assert_no_event_blank_R8: assert property (@(posedge clk) disable iff (rst)
        blank |=> (!slot_start && !bit_valid && !bus_reset));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        (low_us == CNT_MAX && !evt.fall) |=> (low_us == CNT_MAX));

endmodule

// File: rtl/owsf_drive.sv
`timescale 1ns/1ps
module owsf_drive
    import owsf_pkg::*;
#(
    parameter int unsigned CLK_PER_US  = 200,
    parameter int unsigned PRESENCE_US = 120,
    parameter int unsigned TXZ_US      = 15,
    parameter int unsigned GUARD_CYC   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic slot_start,
    input  logic tx_zero_req,
    output logic line_pull,
    output logic blank
);
    localparam int unsigned PS_W = $clog2(CLK_PER_US);
    localparam int unsigned US_W = $clog2(max2(PRESENCE_US, TXZ_US) + 1);
    localparam int unsigned G_W  = $clog2(GUARD_CYC + 1);
    localparam logic [PS_W-1:0] PS_TOP = PS_W'(CLK_PER_US - 1);

    drv_mode_e       mode;
    logic [PS_W-1:0] ps;
    logic [US_W-1:0] us_left;
    logic [G_W-1:0]  guard;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= DRV_IDLE;
            ps      <= '0;
            us_left <= '0;
            guard   <= '0;
        end else if (bus_reset) begin
            // reset aborts anything in progress and starts presence
            mode    <= DRV_PRES;
            ps      <= '0;
            us_left <= US_W'(PRESENCE_US);
            guard   <= '0;
        end else if (mode == DRV_IDLE) begin
            if (guard != '0) guard <= guard - 1'b1;
            if (slot_start && tx_zero_req) begin
                mode    <= DRV_TXZ;
                ps      <= '0;
                us_left <= US_W'(TXZ_US);
            end
        end else if (ps == PS_TOP) begin
            ps <= '0;
            if (us_left == US_W'(1)) begin
                mode  <= DRV_IDLE;
                guard <= G_W'(GUARD_CYC);
            end else begin
                us_left <= us_left - 1'b1;
            end
        end else begin
            ps <= ps + 1'b1;
        end
    end

    assign line_pull = (mode != DRV_IDLE);
    assign blank     = line_pull || (guard != '0);

    assert_pres_start_R3: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (mode == DRV_PRES && line_pull));

    assert_txz_start_R7: assert property (@(posedge clk) disable iff (rst)
        (slot_start && tx_zero_req && !bus_reset) |=> (mode == DRV_TXZ));

    assert_reset_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && tx_zero_req) |=> (mode == DRV_PRES));

    assert_release_guard_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(line_pull) |-> blank);

endmodule

// File: rtl/owire_slot_front.sv
`timescale 1ns/1ps
module owire_slot_front
    import owsf_pkg::*;
#(
    parameter int unsigned CLK_PER_US  = 200,
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned RESET_US    = 256,
    parameter int unsigned ONE_MAX_US  = 15,
    parameter int unsigned PRESENCE_US = 120,
    parameter int unsigned TXZ_US      = 15,
    parameter int unsigned GUARD_CYC   = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic tx_zero_req,
    output logic line_pull,
    output logic bus_reset,
    output logic slot_start,
    output logic bit_valid,
    output logic bit_value
);
    line_evt_t evt;
    logic      blank;

    owsf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_raw (line_in),
        .blank    (blank),
        .evt      (evt)
    );

    owsf_lowtime #(
        .CLK_PER_US (CLK_PER_US),
        .CNT_W      (CNT_W),
        .RESET_US   (RESET_US),
        .ONE_MAX_US (ONE_MAX_US)
    ) u_lowtime (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .blank      (blank),
        .bus_reset  (bus_reset),
        .slot_start (slot_start),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value)
    );

    owsf_drive #(
        .CLK_PER_US  (CLK_PER_US),
        .PRESENCE_US (PRESENCE_US),
        .TXZ_US      (TXZ_US),
        .GUARD_CYC   (GUARD_CYC)
    ) u_drive (
        .clk         (clk),
        .rst         (rst),
        .bus_reset   (bus_reset),
        .slot_start  (slot_start),
        .tx_zero_req (tx_zero_req),
        .line_pull   (line_pull),
        .blank       (blank)
    );

endmodule

// File: tb/owire_slot_front_bench.sv
`timescale 1ns/1ps
module owire_slot_front_bench;
    localparam int CPU = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_low = 1'b0;
    logic tx_req = 1'b0;
    logic line_in, line_pull, bus_reset, slot_start, bit_valid, bit_value;

    assign line_in = ~(m_low | line_pull);

    owire_slot_front #(.CLK_PER_US(CPU)) u_owire_slot_front (
        .clk(clk), .rst(rst), .line_in(line_in), .tx_zero_req(tx_req),
        .line_pull(line_pull), .bus_reset(bus_reset), .slot_start(slot_start),
        .bit_valid(bit_valid), .bit_value(bit_value)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    int n_rst, n_bit, n_slot, n_pull, last_val, t_bit, t_slot, t_pull, t_rst;
    int total = 0;
    int fails = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_reset) begin n_rst++; t_rst = cyc; end
            if (bit_valid) begin n_bit++; last_val = int'(bit_value); t_bit = cyc; end
            if (slot_start) begin n_slot++; t_slot = cyc; end
            if (line_pull) begin
                if (n_pull == 0) t_pull = cyc;
                n_pull++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // txmode: 0 none, 1 request at slot start, 2 request raised late in the low
    task automatic do_slot(input int len_us, input int txmode);
        int t_fall, t_rise, exp_pull, exp_bit;
        bit is_rst;
        @(negedge clk);
        n_rst = 0; n_bit = 0; n_slot = 0; n_pull = 0; last_val = -1;
        tx_req = (txmode == 1);
        m_low = 1'b1;
        t_fall = cyc;
        for (int i = 0; i < len_us * CPU; i++) begin
            @(negedge clk);
            if (txmode == 2 && i == 20) tx_req = 1'b1;
        end
        m_low = 1'b0;
        t_rise = cyc;
        repeat (125 * CPU + 24) @(negedge clk);
        tx_req = 1'b0;
        is_rst   = (len_us > 256);
        exp_bit  = (!is_rst && txmode != 1) ? 1 : 0;
        exp_pull = is_rst ? 120 * CPU : (txmode == 1 ? 15 * CPU : 0);
        check(n_slot == 1, "R6 slot_start count", n_slot, 1);
        check(t_slot - t_fall == 3, "R11 slot_start latency", t_slot - t_fall, 3);
        check(n_rst == int'(is_rst), is_rst ? "R2 reset strobe" : "R5 no reset", n_rst, int'(is_rst));
        check(n_bit == exp_bit, txmode == 1 ? "R8 bit count" : "R2 bit count", n_bit, exp_bit);
        if (exp_bit == 1) begin
            check(last_val == int'(len_us <= 15), len_us <= 15 ? "R4 bit value" : "R5 bit value",
                  last_val, int'(len_us <= 15));
            check(t_bit - t_rise == 3, "R11 bit latency", t_bit - t_rise, 3);
        end
        if (is_rst) begin
            check(n_pull == exp_pull, txmode == 2 ? "R10 presence length" : "R3 presence length",
                  n_pull, exp_pull);
            check(t_rst - t_rise == 3, "R11 reset latency", t_rst - t_rise, 3);
            check(t_pull - t_rst == 1, "R3 presence start", t_pull - t_rst, 1);
        end else begin
            check(n_pull == exp_pull, "R7 drive length", n_pull, exp_pull);
            if (exp_pull != 0)
                check(t_pull - t_slot == 1, "R7 drive start", t_pull - t_slot, 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0417));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!line_pull && !bus_reset && !slot_start && !bit_valid && !bit_value,
              "R1 reset state", int'({line_pull, bus_reset, slot_start, bit_valid, bit_value}), 0);
        repeat (8) @(negedge clk);
        do_slot(15, 0);   // R4 boundary
        do_slot(16, 0);   // R5 boundary
        do_slot(1, 0);    // R4
        do_slot(256, 0);  // R2 / R5 upper bound
        do_slot(257, 0);  // R2 reset boundary
        do_slot(600, 0);  // R9 saturation
        do_slot(2, 1);    // R7 / R8 read zero
        do_slot(300, 2);  // R10 reset with pending request
        do_slot(40, 2);   // R7 late request ignored
        for (int k = 0; k < 25; k++) begin
            int len;
            int mode;
            len = 1 + int'($urandom % 320);
            if (len <= 10) mode = int'($urandom % 2);
            else mode = ($urandom % 2 == 0) ? 0 : 2;
            do_slot(len, mode);
        end
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

endmodule